// File: doc/BRIEF.md
# Blocking Message Channel Bank

This block sits between a processor core and the devices attached to it. It holds a set of one-way message channels. Each channel is a small queue with a fixed direction. Outbound channels carry words from the core to a device. Inbound channels carry words from a device to the core. A device may own any number of channels. It drains or fills each of them through a per-channel pop or push port.

The core issues one access at a time. An access names a channel and one of three operations: read a message, write a message, or read the channel's count. For an outbound channel the count is the number of free slots. For an inbound channel it is the number of messages waiting. Writes go through without delay while the queue has room. A write to a full channel, or a read from an empty one, does not fault. The core holds the access and waits on the registered `stall_o` line. The access completes in the cycle the device frees a slot or delivers a word.

Top module: `msgch_bank`

## Requirements
- R1: The operation code on `req_op_i` is 2'b00 read, 2'b01 write, 2'b10 read count, and 2'b11 is illegal. With `req_valid_i` low, `rsp_done_o` and `rsp_err_o` stay low. Channels 0..NUM_CH-1 exist. Bit i of DIR_MASK set makes channel i outbound. The defaults (NUM_CH=8, DIR_MASK=8'h0F) make channels 0-3 outbound and 4-7 inbound.
- R2: A core write to an outbound channel that is not full raises `rsp_done_o` in the same cycle. The device sees words in write order: the oldest word is at slice c of `dn_data_o` while `dn_valid_o[c]` is high, and a pulse on `dn_pop_i[c]` removes it.
- R3: DEPTH back-to-back writes to an empty outbound channel all complete without a stall. Write DEPTH+1 is blocked.
- R4: A count access always completes in its own cycle, even on an empty or full channel. It returns the free slots of an outbound channel or the waiting messages of an inbound channel, zero-extended on `rsp_data_o`.
- R5: A core read from a non-empty inbound channel completes in the same cycle. It returns the oldest message, in device push order.
- R6: A blocked access keeps `rsp_done_o` low. `stall_o` rises in the next cycle and stays high while the access is held.
- R7: A held write completes in the cycle the device pops. A held read completes in the cycle the device pushes, and the pushed word goes straight to `rsp_data_o` without being stored. `stall_o` falls in the following cycle.
- R8: These accesses complete at once with `rsp_err_o` high and `rsp_data_o` zero: a channel number of NUM_CH or above, a write to an inbound channel, a read from an outbound channel, or the illegal code. They change no queue and raise no stall.
- R9: A device transfer and a core transfer on the same channel in the same cycle are both honoured. The channel's count is unchanged.
- R10: A device push to a full inbound channel (`up_ready_o[c]` low) with no core read in that cycle is dropped. A device pop on an empty outbound channel (`dn_valid_o[c]` low) is ignored.
- R11: After reset every queue is empty. `stall_o` is low, outbound counts read DEPTH, inbound counts read 0, all `dn_valid_o` are low, and `up_ready_o` is high on every inbound channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Core access present, held until done |
| req_op_i | input | 2 | Operation code |
| req_ch_i | input | CH_W (7) | Channel number |
| req_wdata_i | input | DATA_W (32) | Write message |
| rsp_done_o | output | 1 | Access completes this cycle |
| rsp_data_o | output | DATA_W (32) | Read message or count |
| rsp_err_o | output | 1 | Illegal access |
| stall_o | output | 1 | Core held in wait state |
| dn_valid_o | output | NUM_CH (8) | Outbound channel has a word |
| dn_data_o | output | NUM_CH*DATA_W (256) | Oldest outbound word per channel |
| dn_pop_i | input | NUM_CH (8) | Device takes the outbound word |
| up_ready_o | output | NUM_CH (8) | Inbound channel has room |
| up_push_i | input | NUM_CH (8) | Device pushes an inbound word |
| up_data_i | input | NUM_CH*DATA_W (256) | Inbound word per channel |

## Verification
Outbound channels are filled to the brim and then released by a device pop while the core waits. This separates a correct capacity edge from an off-by-one, and it shows whether completion lands in the release cycle. Inbound channels are tried three ways: read after several pushes, read while empty with a late push, and read during a push. Together these show ordering, the bypass path, and count invariance under simultaneous transfers. Illegal channels, wrong directions and the illegal code are mixed with count readbacks before and after. Any hidden change to a queue shows up in those counts.

// File: rtl/msgch_pkg.sv
package msgch_pkg;
  typedef enum logic [1:0] {
    OP_RD  = 2'b00,
    OP_WR  = 2'b01,
    OP_CNT = 2'b10,
    OP_BAD = 2'b11
  } op_e;
endpackage

// File: rtl/msgch_fifo.sv
module msgch_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  parameter bit BYPASS = 1'b0,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic              full_o,
  output logic              empty_o,
  output logic [CNT_W-1:0]  level_o,
  output logic              push_ok_o,
  output logic              pop_ok_o
);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  rd_ptr_q, wr_ptr_q;
  logic [CNT_W-1:0]  level_q;
  logic              byp, do_wr, do_rd;

  assign full_o  = (level_q == FULL_LVL);
  assign empty_o = (level_q == '0);
  assign level_o = level_q;

  // variant: inbound queues hand a word straight through when empty
  if (BYPASS) begin : g_byp
    assign byp    = empty_o & push_i & pop_i;
    assign head_o = empty_o ? push_data_i : mem_q[rd_ptr_q];
  end else begin : g_nobyp
    assign byp    = 1'b0;
    assign head_o = mem_q[rd_ptr_q];
  end

  assign pop_ok_o  = pop_i & (~empty_o | byp);
  assign push_ok_o = push_i & (~full_o | pop_i);
  assign do_wr     = push_ok_o & ~byp;
  assign do_rd     = pop_ok_o & ~byp;

  always_ff @(posedge clk_i) begin
    if (do_wr) mem_q[wr_ptr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (do_wr) wr_ptr_q <= (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
      if (do_rd) rd_ptr_q <= (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end
endmodule

// File: rtl/msgch_decode.sv
module msgch_decode
  import msgch_pkg::*;
#(
  parameter int          NUM_CH   = 8,
  parameter int          CH_W     = 7,
  parameter int          DATA_W   = 32,
  parameter int          CNT_W    = 3,
  parameter logic [NUM_CH-1:0] DIR_MASK = '0
) (
  input  logic                           req_valid_i,
  input  op_e                            op_i,
  input  logic [CH_W-1:0]                ch_i,
  input  logic [NUM_CH-1:0]              push_ok_i,
  input  logic [NUM_CH-1:0]              pop_ok_i,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  head_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0]   cnt_i,
  output logic [NUM_CH-1:0]              wr_sel_o,
  output logic [NUM_CH-1:0]              rd_sel_o,
  output logic                           done_o,
  output logic [DATA_W-1:0]              data_o,
  output logic                           err_o
);
  logic              in_rng, s_out, s_push_ok, s_pop_ok;
  logic [DATA_W-1:0] s_head;
  logic [CNT_W-1:0]  s_cnt;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    logic hit;
    assign hit         = req_valid_i & (ch_i == CH_W'(c));
    assign wr_sel_o[c] = hit & (op_i == OP_WR) & DIR_MASK[c];
    assign rd_sel_o[c] = hit & (op_i == OP_RD) & ~DIR_MASK[c];
  end

  always_comb begin
    in_rng    = 1'b0;
    s_out     = 1'b0;
    s_push_ok = 1'b0;
    s_pop_ok  = 1'b0;
    s_head    = '0;
    s_cnt     = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_i == CH_W'(i)) begin
        in_rng    = 1'b1;
        s_out     = DIR_MASK[i];
        s_push_ok = push_ok_i[i];
        s_pop_ok  = pop_ok_i[i];
        s_head    = head_i[i];
        s_cnt     = cnt_i[i];
      end
    end
  end

  always_comb begin
    done_o = 1'b0;
    err_o  = 1'b0;
    data_o = '0;
    if (req_valid_i) begin
      unique case (op_i)
        OP_CNT: begin
          done_o = 1'b1;
          err_o  = ~in_rng;
          if (in_rng) data_o = {{(DATA_W-CNT_W){1'b0}}, s_cnt};
        end
        OP_WR: begin
          if (in_rng && s_out) done_o = s_push_ok;
          else begin
            done_o = 1'b1;
            err_o  = 1'b1;
          end
        end
        OP_RD: begin
          if (in_rng && !s_out) begin
            done_o = s_pop_ok;
            if (s_pop_ok) data_o = s_head;
          end else begin
            done_o = 1'b1;
            err_o  = 1'b1;
          end
        end
        default: begin
          done_o = 1'b1;
          err_o  = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/msgch_stall.sv
module msgch_stall (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_valid_i,
  input  logic done_i,
  output logic stall_o
);
  logic stall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stall_q <= 1'b0;
    else         stall_q <= req_valid_i & ~done_i;
  end

  assign stall_o = stall_q;
endmodule

// File: rtl/msgch_bank.sv
module msgch_bank
  import msgch_pkg::*;
#(
  parameter int                NUM_CH   = 8,
  parameter int                CH_W     = 7,
  parameter int                DATA_W   = 32,
  parameter int                DEPTH    = 4,
  parameter logic [NUM_CH-1:0] DIR_MASK = 8'h0F
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_valid_i,
  input  logic [1:0]               req_op_i,
  input  logic [CH_W-1:0]          req_ch_i,
  input  logic [DATA_W-1:0]        req_wdata_i,
  output logic                     rsp_done_o,
  output logic [DATA_W-1:0]        rsp_data_o,
  output logic                     rsp_err_o,
  output logic                     stall_o,
  output logic [NUM_CH-1:0]        dn_valid_o,
  output logic [NUM_CH*DATA_W-1:0] dn_data_o,
  input  logic [NUM_CH-1:0]        dn_pop_i,
  output logic [NUM_CH-1:0]        up_ready_o,
  input  logic [NUM_CH-1:0]        up_push_i,
  input  logic [NUM_CH*DATA_W-1:0] up_data_i
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

  logic [NUM_CH-1:0]             wr_sel, rd_sel, push_ok_v, pop_ok_v;
  logic [NUM_CH-1:0][DATA_W-1:0] head_v;
  logic [NUM_CH-1:0][CNT_W-1:0]  cnt_v;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic              push, pop, full, empty, push_ok, pop_ok;
    logic [DATA_W-1:0] pdata, head;
    logic [CNT_W-1:0]  level;
    logic              unused_ch;

    if (DIR_MASK[c]) begin : g_out
      assign push  = wr_sel[c];
      assign pdata = req_wdata_i;
      assign pop   = dn_pop_i[c];
      msgch_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .BYPASS(1'b0)) u_q (
        .clk_i, .rst_ni,
        .push_i(push), .push_data_i(pdata), .pop_i(pop),
        .head_o(head), .full_o(full), .empty_o(empty), .level_o(level),
        .push_ok_o(push_ok), .pop_ok_o(pop_ok)
      );
      assign dn_valid_o[c]                 = ~empty;
      assign dn_data_o[c*DATA_W +: DATA_W] = head;
      assign up_ready_o[c]                 = 1'b0;
      assign cnt_v[c]                      = CAP - level;
      assign head_v[c]                     = '0;
      assign push_ok_v[c]                  = push_ok;
      assign pop_ok_v[c]                   = 1'b0;
      assign unused_ch = ^{up_push_i[c], up_data_i[c*DATA_W +: DATA_W],
                           rd_sel[c], full, pop_ok};
    end else begin : g_in
      assign push  = up_push_i[c];
      assign pdata = up_data_i[c*DATA_W +: DATA_W];
      assign pop   = rd_sel[c];
      msgch_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .BYPASS(1'b1)) u_q (
        .clk_i, .rst_ni,
        .push_i(push), .push_data_i(pdata), .pop_i(pop),
        .head_o(head), .full_o(full), .empty_o(empty), .level_o(level),
        .push_ok_o(push_ok), .pop_ok_o(pop_ok)
      );
      assign dn_valid_o[c]                 = 1'b0;
      assign dn_data_o[c*DATA_W +: DATA_W] = '0;
      assign up_ready_o[c]                 = ~full;
      assign cnt_v[c]                      = level;
      assign head_v[c]                     = head;
      assign push_ok_v[c]                  = 1'b0;
      assign pop_ok_v[c]                   = pop_ok;
      assign unused_ch = ^{dn_pop_i[c], wr_sel[c], empty, push_ok};
    end
  end

  msgch_decode #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .DIR_MASK(DIR_MASK)
  ) u_dec (
    .req_valid_i, .op_i(op_e'(req_op_i)), .ch_i(req_ch_i),
    .push_ok_i(push_ok_v), .pop_ok_i(pop_ok_v), .head_i(head_v), .cnt_i(cnt_v),
    .wr_sel_o(wr_sel), .rd_sel_o(rd_sel),
    .done_o(rsp_done_o), .data_o(rsp_data_o), .err_o(rsp_err_o)
  );

  msgch_stall u_stall (
    .clk_i, .rst_ni, .req_valid_i, .done_i(rsp_done_o), .stall_o
  );
endmodule

// File: rtl/msgch_bank_chk.sv
module msgch_bank_chk #(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 7,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_valid_i,
  input logic [1:0]           req_op_i,
  input logic [CH_W-1:0]      req_ch_i,
  input logic                 rsp_done_o,
  input logic [DATA_W-1:0]    rsp_data_o,
  input logic                 rsp_err_o,
  input logic                 stall_o,
  input logic [NUM_CH-1:0]    dn_valid_o,
  input logic [NUM_CH-1:0]    up_ready_o
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (!rsp_done_o && !rsp_err_o)); // R1

  AST_BLOCK_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !rsp_done_o) |=> stall_o); // R6

  AST_RELEASE_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && rsp_done_o) |=> !stall_o); // R7

  AST_ERR_IMMEDIATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> (rsp_done_o && rsp_data_o == '0)); // R8

  AST_COUNT_NOWAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 2'b10) |-> rsp_done_o); // R4

  AST_COUNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_op_i == 2'b10 && !rsp_err_o) |-> (rsp_data_o <= DATA_W'(DEPTH))); // R4

  AST_ERR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ch_i >= CH_W'(NUM_CH)) |-> rsp_err_o); // R8

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dir
    AST_ONE_DIRECTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(dn_valid_o[c] && up_ready_o[c])); // R1
  end
endmodule

bind msgch_bank msgch_bank_chk #(
  .NUM_CH(NUM_CH), .CH_W(CH_W), .DATA_W(DATA_W), .DEPTH(DEPTH)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_op_i(req_op_i),
  .req_ch_i(req_ch_i), .rsp_done_o(rsp_done_o), .rsp_data_o(rsp_data_o),
  .rsp_err_o(rsp_err_o), .stall_o(stall_o), .dn_valid_o(dn_valid_o),
  .up_ready_o(up_ready_o)
);

// File: tb/msgch_bank_tb.sv
module msgch_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 8;
  localparam int DW     = 32;
  localparam logic [1:0] RD = 2'b00, WR = 2'b01, CNT = 2'b10, BAD = 2'b11;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_valid_i;
  logic [1:0] req_op_i;
  logic [6:0] req_ch_i;
  logic [DW-1:0] req_wdata_i;
  logic rsp_done_o, rsp_err_o, stall_o;
  logic [DW-1:0] rsp_data_o;
  logic [NUM_CH-1:0] dn_valid_o, dn_pop_i, up_ready_o, up_push_i;
  logic [NUM_CH*DW-1:0] dn_data_o, up_data_i;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  msgch_bank u_dut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk_i);
    req_valid_i = 1'b0; req_op_i = RD; req_ch_i = '0; req_wdata_i = '0;
    dn_pop_i = '0; up_push_i = '0; up_data_i = '0;
  endtask

  task automatic core(logic [1:0] op, int ch, logic [31:0] d);
    req_valid_i = 1'b1; req_op_i = op; req_ch_i = 7'(ch); req_wdata_i = d;
  endtask

  task automatic dpush(int ch, logic [31:0] d);
    up_push_i[ch] = 1'b1; up_data_i[ch*DW +: DW] = d;
  endtask

  task automatic count_is(string tag, int ch, int exp);
    nxt(); core(CNT, ch, 0); #1;
    chk({tag, " count done"}, 32'(rsp_done_o), 1);
    chk({tag, " count"}, rsp_data_o, 32'(exp));
  endtask

  task automatic t_reset();
    nxt(); #1;
    chk("R11 stall low", 32'(stall_o), 0);
    chk("R11 dn_valid", 32'(dn_valid_o), 0);
    chk("R11 up_ready", 32'(up_ready_o), 32'h0F0);
    chk("R1 idle no done", 32'(rsp_done_o), 0);
    count_is("R11 out", 0, 4);
    count_is("R11 in", 4, 0);
  endtask

  task automatic t_out_fill();
    for (int k = 0; k < 4; k++) begin
      nxt(); core(WR, 1, 32'h100 + k); #1;
      chk("R3 write no stall", 32'(rsp_done_o), 1);
    end
    count_is("R4 out full", 1, 0);
    chk("R2 dn_valid", 32'(dn_valid_o[1]), 1);
    chk("R2 oldest word", dn_data_o[1*DW +: DW], 32'h100);
    nxt(); core(WR, 1, 32'h104); #1;
    chk("R3 fifth write blocked", 32'(rsp_done_o), 0);
    nxt(); core(WR, 1, 32'h104); #1;
    chk("R6 stall raised", 32'(stall_o), 1);
    chk("R6 still blocked", 32'(rsp_done_o), 0);
    nxt(); core(WR, 1, 32'h104); dn_pop_i[1] = 1'b1; #1;
    chk("R7 write completes on pop", 32'(rsp_done_o), 1);
    chk("R2 pop sees first", dn_data_o[1*DW +: DW], 32'h100);
    nxt(); #1;
    chk("R7 stall drops", 32'(stall_o), 0);
    for (int k = 1; k < 5; k++) begin
      nxt(); dn_pop_i[1] = 1'b1; #1;
      chk("R2 order", dn_data_o[1*DW +: DW], 32'h100 + k);
    end
    nxt(); #1;
    chk("R2 drained", 32'(dn_valid_o[1]), 0);
    count_is("R4 out empty", 1, 4);
  endtask

  task automatic t_in_read();
    for (int k = 0; k < 3; k++) begin
      nxt(); dpush(5, 32'h500 + k); #1;
      chk("R10 ready with room", 32'(up_ready_o[5]), 1);
    end
    count_is("R4 in waiting", 5, 3);
    for (int k = 0; k < 3; k++) begin
      nxt(); core(RD, 5, 0); #1;
      chk("R5 read done", 32'(rsp_done_o), 1);
      chk("R5 read order", rsp_data_o, 32'h500 + k);
    end
    count_is("R4 in empty no stall", 5, 0);
  endtask

  task automatic t_in_wait();
    nxt(); core(RD, 6, 0); #1;
    chk("R6 empty read blocked", 32'(rsp_done_o), 0);
    nxt(); core(RD, 6, 0); #1;
    chk("R6 stall on read", 32'(stall_o), 1);
    nxt(); core(RD, 6, 0); dpush(6, 32'hCAFE); #1;
    chk("R7 read completes on push", 32'(rsp_done_o), 1);
    chk("R7 bypass data", rsp_data_o, 32'hCAFE);
    nxt(); #1;
    chk("R7 stall drops after read", 32'(stall_o), 0);
    count_is("R7 bypassed not stored", 6, 0);
  endtask

  task automatic t_simul();
    nxt(); dpush(4, 32'hA); #1;
    nxt(); dpush(4, 32'hB); core(RD, 4, 0); #1;
    chk("R9 read during push", rsp_data_o, 32'hA);
    count_is("R9 in level kept", 4, 1);
    nxt(); core(RD, 4, 0); #1;
    chk("R9 second word", rsp_data_o, 32'hB);
    nxt(); core(WR, 3, 32'h30); #1;
    nxt(); core(WR, 3, 32'h31); dn_pop_i[3] = 1'b1; #1;
    chk("R9 out write during pop", 32'(rsp_done_o), 1);
    chk("R9 pop sees older", dn_data_o[3*DW +: DW], 32'h30);
    count_is("R9 out level kept", 3, 3);
    nxt(); dn_pop_i[3] = 1'b1; #1;
    chk("R9 newer word", dn_data_o[3*DW +: DW], 32'h31);
  endtask

  task automatic t_err();
    logic [1:0] ops[6] = '{WR, RD, WR, BAD, CNT, RD};
    int chs[6] = '{100, 0, 4, 1, 9, 8};
    for (int k = 0; k < 6; k++) begin
      nxt(); core(ops[k], chs[k], 32'hDEAD); #1;
      chk(k == 3 ? "R1 illegal code err" : "R8 err flag", 32'(rsp_err_o), 1);
      chk("R8 err done", 32'(rsp_done_o), 1);
      chk("R8 err data zero", rsp_data_o, 0);
    end
    nxt(); #1;
    chk("R8 no stall", 32'(stall_o), 0);
    count_is("R8 inbound untouched", 4, 0);
    count_is("R8 outbound untouched", 0, 4);
  endtask

  task automatic t_ignore();
    for (int k = 0; k < 5; k++) begin
      nxt(); dpush(7, 32'h700 + k); #1;
      chk("R10 ready flag", 32'(up_ready_o[7]), (k < 4) ? 1 : 0);
    end
    count_is("R10 full inbound", 7, 4);
    for (int k = 0; k < 4; k++) begin
      nxt(); core(RD, 7, 0); #1;
      chk("R10 extra push dropped", rsp_data_o, 32'h700 + k);
    end
    count_is("R10 drained", 7, 0);
    nxt(); dn_pop_i[2] = 1'b1; #1;
    chk("R10 empty pop", 32'(dn_valid_o[2]), 0);
    nxt(); core(WR, 2, 32'h222); #1;
    nxt(); #1;
    chk("R10 word after ignored pop", dn_data_o[2*DW +: DW], 32'h222);
    chk("R10 valid after write", 32'(dn_valid_o[2]), 1);
    count_is("R10 one word", 2, 3);
    nxt(); dn_pop_i[2] = 1'b1; #1;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    req_valid_i = 1'b0; req_op_i = RD; req_ch_i = '0; req_wdata_i = '0;
    dn_pop_i = '0; up_push_i = '0; up_data_i = '0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    t_reset();
    t_out_fill();
    t_in_read();
    t_in_wait();
    t_simul();
    t_err();
    t_ignore();
    nxt();
    if (!finished) begin
      finished = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule